// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address from the processor side into a physical address. It does this by fetching one page-table entry from memory. The virtual address splits into a virtual page number (the upper VA_W−PAGE_BITS bits) and a byte offset (the low PAGE_BITS bits). The page number is first compared against a configured table length. A number outside that range faults at once, and no memory traffic is issued. For a legal page, the walker forms the entry address from a configured table base. It then issues a single read and waits for the data for as many cycles as memory takes. The entry's present bit and write-permission bit are then checked. When the access is allowed, the frame number from the entry is joined to the offset.

Only one translation is in flight at a time. A request is taken only while the walker is idle. The answer stays on the response port until the requester takes it, and only then does the walker accept new work. The table base and table length inputs must be held steady while a translation is in progress.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, rsp_valid is 0 and mem_rd_en is 0.
- R2: A request is accepted on a cycle with req_valid and req_ready both high. From then on req_ready stays low until the cycle after the response is taken (rsp_valid and rsp_ready both high), when it returns to 1.
- R3: If the page number (vaddr[VA_W-1:PAGE_BITS]) is greater than or equal to cfg_len, the response has rsp_cause 1 and rsp_fault 1, and mem_rd_en never rises during that translation.
- R4: For a legal page number, exactly one single-cycle mem_rd_en pulse is issued, with mem_rd_addr equal to cfg_base + 4 × page number, wrapped to PA_W bits.
- R5: After the read pulse, the walker waits any number of cycles for mem_rd_dv. mem_rd_data is ignored on cycles where mem_rd_dv is low, and is taken only on cycles after the read pulse.
- R6: An entry whose bit 0 (present) is 0 gives rsp_cause 2, whatever the access type and bit 1.
- R7: A write to a present entry whose bit 1 (writable) is 0 gives rsp_cause 3. A read of such an entry succeeds.
- R8: A permitted access responds with rsp_cause 0 and rsp_fault 0. Its rsp_paddr is {entry bits [31:12], vaddr[PAGE_BITS-1:0]}.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_paddr and rsp_cause do not change.
- R10: rsp_fault is 1 exactly when rsp_cause is nonzero, and rsp_paddr is 0 on every faulting response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | PA_W | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 2 | 0 ok, 1 beyond length, 2 not present, 3 write to read-only |
| mem_rd_en | output | 1 | One-cycle read strobe for the entry |
| mem_rd_addr | output | PA_W | Byte address of the entry |
| mem_rd_dv | input | 1 | Entry data valid |
| mem_rd_data | input | 32 | Entry contents |
| cfg_base | input | PA_W | Byte address of entry 0 |
| cfg_len | input | VA_W-PAGE_BITS+1 | Number of legal page numbers |

## Verification
Several rules are checked by assertions on every cycle:
- the read strobe is a lone pulse, and none follows a failed length test;
- a pending response stays unchanged;
- faulting responses carry a zero address;
- successful responses keep the requested offset;
- a protection fault is never reported for an entry that is not present.

The bench's scenarios are needed for the rest:
- the exact entry address, including wrap past the top of the address space;
- the choice of fault cause for each mix of present bit, writable bit, access type and bound;
- placement of the frame field;
- tolerance of long and short memory latency while junk appears on the data lines.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ_PTE,
        ST_WAIT_PTE,
        ST_RESPOND
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_BOUND    = 2'd1,
        CAUSE_ABSENT   = 2'd2,
        CAUSE_READONLY = 2'd3
    } fault_cause_e;

    localparam int PTE_W         = 32;
    localparam int PTE_PRESENT   = 0;
    localparam int PTE_WRITABLE  = 1;
    localparam int PTE_FRAME_LSB = 12;
    localparam int FRAME_W       = PTE_W - PTE_FRAME_LSB;

endpackage

// File: rtl/pt_index_split.sv
module pt_index_split
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = FRAME_W + PAGE_BITS
) (
    input  logic [VA_W-1:0]           vaddr,
    input  logic [PA_W-1:0]           table_base,
    input  logic [VA_W-PAGE_BITS:0]   table_len,
    output logic [PAGE_BITS-1:0]      page_offset,
    output logic                      in_bounds,
    output logic [PA_W-1:0]           entry_addr
);
    localparam int VPN_W = VA_W - PAGE_BITS;

    logic [VPN_W-1:0] vpn;

    assign vpn         = vaddr[VA_W-1:PAGE_BITS];
    assign page_offset = vaddr[PAGE_BITS-1:0];
    assign in_bounds   = ({1'b0, vpn} < table_len);
    assign entry_addr  = table_base + PA_W'({vpn, 2'b00});

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = FRAME_W + PAGE_BITS
) (
    input  logic [PTE_W-1:0]     pte,
    input  logic [PAGE_BITS-1:0] page_offset,
    input  logic                 is_write,
    output fault_cause_e         cause,
    output logic [PA_W-1:0]      paddr
);
    logic [FRAME_W-1:0] frame;
    logic               unused_pte_bits;

    assign frame           = pte[PTE_W-1:PTE_FRAME_LSB];
    assign unused_pte_bits = ^pte[PTE_FRAME_LSB-1:PTE_WRITABLE+1];

    always_comb begin
        if (!pte[PTE_PRESENT]) begin
            cause = CAUSE_ABSENT;
        end else if (is_write && !pte[PTE_WRITABLE]) begin
            cause = CAUSE_READONLY;
        end else begin
            cause = CAUSE_NONE;
        end
        paddr = PA_W'({frame, page_offset});
    end

    // R6: protection is only judged on entries that are present
    always_comb begin
        assert_absent_first_R6: assert (cause != CAUSE_READONLY || pte[PTE_PRESENT]);
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = FRAME_W + PAGE_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     req_write,
    output logic                     rsp_valid,
    input  logic                     rsp_ready,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic                     rsp_fault,
    output logic [1:0]               rsp_cause,
    output logic                     mem_rd_en,
    output logic [PA_W-1:0]          mem_rd_addr,
    input  logic                     mem_rd_dv,
    input  logic [PTE_W-1:0]         mem_rd_data,
    input  logic [PA_W-1:0]          cfg_base,
    input  logic [VA_W-PAGE_BITS:0]  cfg_len
);

    typedef struct packed {
        walk_state_e     st;
        logic [VA_W-1:0] va;
        logic            wr;
        fault_cause_e    cause;
        logic [PA_W-1:0] pa;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [PAGE_BITS-1:0] offset;
    logic                 in_bounds;
    logic [PA_W-1:0]      entry_addr;
    fault_cause_e         eval_cause;
    logic [PA_W-1:0]      eval_paddr;

    pt_index_split #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PA_W      (PA_W)
    ) u_split (
        .vaddr       (r_q.va),
        .table_base  (cfg_base),
        .table_len   (cfg_len),
        .page_offset (offset),
        .in_bounds   (in_bounds),
        .entry_addr  (entry_addr)
    );

    pt_entry_eval #(
        .PAGE_BITS (PAGE_BITS),
        .PA_W      (PA_W)
    ) u_eval (
        .pte         (mem_rd_data),
        .page_offset (offset),
        .is_write    (r_q.wr),
        .cause       (eval_cause),
        .paddr       (eval_paddr)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va = req_vaddr;
                    r_d.wr = req_write;
                    r_d.st = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (in_bounds) begin
                    r_d.st = ST_READ_PTE;
                end else begin
                    r_d.cause = CAUSE_BOUND;
                    r_d.pa    = '0;
                    r_d.st    = ST_RESPOND;
                end
            end
            ST_READ_PTE: begin
                r_d.st = ST_WAIT_PTE;
            end
            ST_WAIT_PTE: begin
                if (mem_rd_dv) begin
                    r_d.cause = eval_cause;
                    r_d.pa    = (eval_cause == CAUSE_NONE) ? eval_paddr : '0;
                    r_d.st    = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                if (rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = (r_q.st == ST_RESPOND);
    assign rsp_paddr   = r_q.pa;
    assign rsp_cause   = r_q.cause;
    assign rsp_fault   = (r_q.cause != CAUSE_NONE);
    assign mem_rd_en   = (r_q.st == ST_READ_PTE);
    assign mem_rd_addr = entry_addr;

    // R2: acceptance closes the request port on the next cycle
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a failed length test is never followed by a read
    assert_no_read_on_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && !in_bounds) |=> !mem_rd_en);

    // R4: the entry read strobe lasts a single cycle
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R9: a response waiting for the requester does not move
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)));

    // R10: faulting responses carry no address
    assert_fault_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R8: a good translation keeps the requested offset
    assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == r_q.va[PAGE_BITS-1:0]));

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int PA_W      = 32;
    localparam int VPN_W     = VA_W - PAGE_BITS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VA_W-1:0]   req_vaddr = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [PA_W-1:0]   rsp_paddr;
    logic              rsp_fault;
    logic [1:0]        rsp_cause;
    logic              mem_rd_en;
    logic [PA_W-1:0]   mem_rd_addr;
    logic              mem_rd_dv = 1'b0;
    logic [31:0]       mem_rd_data = '0;
    logic [PA_W-1:0]   cfg_base = '0;
    logic [VPN_W:0]    cfg_len = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_dv(mem_rd_dv), .mem_rd_data(mem_rd_data),
        .cfg_base(cfg_base), .cfg_len(cfg_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_cause(input logic [VPN_W-1:0] vpn, input logic [VPN_W:0] len,
                                             input logic [31:0] pte, input bit wr);
        if ({1'b0, vpn} >= len) return 2'd1;
        if (!pte[0])            return 2'd2;
        if (wr && !pte[1])      return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [PA_W-1:0] exp_paddr(input logic [1:0] cause, input logic [31:0] pte,
                                                  input logic [VA_W-1:0] va);
        if (cause != 2'd0) return '0;
        return {pte[31:12], va[PAGE_BITS-1:0]};
    endfunction

    task automatic walk(input logic [VA_W-1:0] va, input bit wr, input logic [31:0] pte,
                        input int lat, input int hold);
        logic [VPN_W-1:0] vpn;
        logic [1:0]       ec;
        logic [PA_W-1:0]  ep;
        logic [PA_W-1:0]  held_pa;
        logic [1:0]       held_c;
        int reads;
        int cnt;
        bit got;
        vpn   = va[VA_W-1:PAGE_BITS];
        ec    = exp_cause(vpn, cfg_len, pte, wr);
        ep    = exp_paddr(ec, pte, va);
        reads = 0;
        cnt   = -1;
        got   = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = $urandom;
        req_write = $urandom;
        for (int g = 0; g < 80; g++) begin
            if (rsp_valid) begin
                got = 1'b1;
                break;
            end
            chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
            if (mem_rd_en) begin
                reads++;
                chk(mem_rd_addr == cfg_base + PA_W'({vpn, 2'b00}), "R4", "entry address",
                    64'(mem_rd_addr), 64'(cfg_base + PA_W'({vpn, 2'b00})));
                cnt = lat;
            end
            if (cnt == 0) begin
                mem_rd_dv   = 1'b1;
                mem_rd_data = pte;
                cnt = -1;
            end else begin
                mem_rd_dv   = 1'b0;
                mem_rd_data = $urandom;   // R5: junk while not valid
                if (cnt > 0) cnt--;
            end
            @(negedge clk);
        end
        mem_rd_dv = 1'b0;
        chk(got, "R5", "response arrived", 64'(got), 64'd1);
        if (ec == 2'd1)
            chk(reads == 0, "R3", "no read on bound fault", 64'(reads), 64'd0);
        else
            chk(reads == 1, "R4", "single read", 64'(reads), 64'd1);
        chk(rsp_cause == ec,
            (ec == 2'd1) ? "R3" : (ec == 2'd2) ? "R6" : (ec == 2'd3) ? "R7" : "R8",
            "cause", 64'(rsp_cause), 64'(ec));
        chk(rsp_paddr == ep, (ec == 2'd0) ? "R8" : "R10", "paddr", 64'(rsp_paddr), 64'(ep));
        chk(rsp_fault == (ec != 2'd0), "R10", "fault flag", 64'(rsp_fault), 64'(ec != 2'd0));
        held_pa = rsp_paddr;
        held_c  = rsp_cause;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == held_pa && rsp_cause == held_c, "R9", "held response",
                {rsp_valid, rsp_cause, rsp_paddr}, {1'b1, held_c, held_pa});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R2", "idle after take", {rsp_valid, req_ready}, 64'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_en, "R1", "in reset",
            {req_ready, rsp_valid, mem_rd_en}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_en, "R1", "after reset",
            {req_ready, rsp_valid, mem_rd_en}, 64'b100);

        cfg_base = 32'h0010_0000;
        cfg_len  = 21'd16;
        walk({20'd3, 12'h5A4}, 1'b1, 32'hABCD_E003, 1, 0);    // R8 writable write
        walk({20'd15, 12'hFFF}, 1'b0, 32'h1234_5001, 3, 2);   // R8 last legal page, read-only read
        walk({20'd16, 12'h000}, 1'b0, 32'hFFFF_F003, 1, 1);   // R3 first illegal page
        walk({20'hFFFFF, 12'h001}, 1'b1, 32'hFFFF_F003, 1, 0);// R3 far out
        walk({20'd4, 12'h010}, 1'b1, 32'h5555_5002, 2, 0);    // R6 absent, writable bit set
        walk({20'd5, 12'h020}, 1'b1, 32'h5555_5001, 20, 3);   // R7 read-only write, long wait
        walk({20'd6, 12'h030}, 1'b1, 32'h5555_5000, 1, 0);    // R6 before R7
        walk({20'd6, 12'h030}, 1'b0, 32'h5555_5000, 4, 0);    // R6 on read
        cfg_len = 21'd0;
        walk({20'd0, 12'h000}, 1'b0, 32'h0000_1003, 1, 0);    // R3 empty table
        cfg_len  = 21'h100000;
        cfg_base = 32'hFFFF_FFF0;
        walk({20'd8, 12'h7C0}, 1'b0, 32'h0BEE_F003, 2, 0);    // R4 address wraps
        walk({20'hFFFFF, 12'h123}, 1'b1, 32'hFEDC_B003, 5, 1);// R8 full table

        for (int i = 0; i < 200; i++) begin
            logic [VPN_W-1:0] vpn;
            logic [31:0] pte;
            cfg_base = $urandom;
            cfg_len  = 21'($urandom % 64);
            vpn      = VPN_W'($urandom % (int'(cfg_len) + 8));
            pte      = $urandom;
            if ($urandom % 4 != 0) pte[0] = 1'b1;
            walk({vpn, 12'($urandom)}, 1'($urandom), pte, 1 + ($urandom % 8), $urandom % 4);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule